// File: doc/BRIEF.md
# Three-Channel Matrix Color Converter

This block maps one pixel from one color space to another. Each cycle it takes three input components together and computes three output components. Each output is a weighted sum of the three inputs plus a constant. The weights and constants are elaboration-time parameters given in thousandths. By default they hold the common studio-range conversion from gamma-corrected RGB to luma plus two color-difference channels. The block turns them into fixed-point integers with one shared power-of-two scale. That scale is the largest one that still lets every weight fit the chosen coefficient width.

Every result leaves as a full-precision two's-complement word. That word is the true value multiplied by 2^X, so the consumer chooses its own rounding and clipping. A valid flag travels beside the data through the pipeline. A clock enable freezes the whole pipeline. A synchronous clear, honoured only while the enable is high, empties it. An optional input register adds one cycle. The inputs can be treated as unsigned or as two's complement.

Top module: `csc_matrix3`

## Requirements
- R1: Every cycle, each output k equals qk0*in0 + qk1*in1 + qk2*in2 + ok, taken modulo 2^FULL_W. Here q = round-half-away-from-zero(weight_milli * 2^X / 1000), and the offset o is scaled by the same rule.
- R2: X is the largest integer for which every scaled weight lies in [-2^(COEF_W-1), 2^(COEF_W-1)-1]. X also stays at or below COEF_W + DIN_W - ceil(log2(ceil(max|offset|)))). With the defaults, X is 17, so an all-zero input gives 16*2^17 on output 0 and 128*2^17 on outputs 1 and 2.
- R3: With SIGNED_IN=0, inputs are zero-extended, so an all-ones input counts as 2^DIN_W-1. FULL_W is DIN_W + COEF_W + 2, which is 28 by default.
- R4: With SIGNED_IN=1, inputs are two's complement and FULL_W is DIN_W + COEF_W + 1.
- R5: With REG_IN=1, a sample reaches the outputs exactly 4 enabled cycles after it is applied. vld_out repeats vld_in with the same delay, and one result comes out per enabled cycle.
- R6: While clk_en is low, all outputs and all state hold, and vld_in, the data inputs and sync_clr are ignored.
- R7: When clk_en and sync_clr are both high at an edge, every pipeline register clears. After that edge vld_out is 0 and all results are 0. Samples that were in flight are lost.
- R8: While rst_n is low, vld_out and all results are 0, independent of the clock.
- R9: With REG_IN=0, the delay from input to output is 3 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Pipeline enable; low freezes all state |
| sync_clr | input | 1 | Synchronous clear, effective only with clk_en high |
| vld_in | input | 1 | Marks a valid sample on the inputs |
| src0 | input | DIN_W | First input component |
| src1 | input | DIN_W | Second input component |
| src2 | input | DIN_W | Third input component |
| vld_out | output | 1 | Marks a valid result on the outputs |
| res0 | output | FULL_W | First output component, scaled by 2^X |
| res1 | output | FULL_W | Second output component, scaled by 2^X |
| res2 | output | FULL_W | Third output component, scaled by 2^X |

## Verification
The assertions check four things on every cycle. The valid flag repeats its input after the fixed delay whenever a full window of enabled, uncleared edges lies behind it. A disabled edge leaves the valid flag and the data unchanged. An enabled clear, and the release of the asynchronous reset, both leave an empty, zeroed output. The arithmetic itself can only be shown by the bench scenarios. These cover the quantised weights and the scaled offset, zero-extension against sign-extension, wrap at the full width, and samples that survive a long freeze with clear held high.

// File: rtl/csc_pkg.sv
package csc_pkg;

  // Scale a value given in thousandths by 2^sh, rounding half away from zero.
  function automatic longint q_round(input longint milli, input int sh);
    longint n;
    n = milli * (longint'(1) << sh);
    if (n >= 0) return (n + 500) / 1000;
    else        return -((500 - n) / 1000);
  endfunction

  function automatic bit in_range(input longint v, input int w);
    longint hi;
    hi = (longint'(1) << (w - 1)) - 1;
    return (v >= -hi - 1) && (v <= hi);
  endfunction

  // ceil(log2) of the largest offset magnitude, rounded up to an integer.
  function automatic int ofs_bits(input int om [3]);
    int mag;
    int ip;
    int y;
    mag = 0;
    for (int k = 0; k < 3; k++) begin
      if ((om[k] < 0 ? -om[k] : om[k]) > mag) mag = (om[k] < 0 ? -om[k] : om[k]);
    end
    ip = (mag + 999) / 1000;
    y  = 0;
    for (int t = 0; t < 31; t++) begin
      if ((1 << y) < ip) y = y + 1;
    end
    return y;
  endfunction

  // Largest shared scale exponent that keeps every weight in range.
  function automatic int pick_x(input int cm [9], input int om [3],
                                input int cw, input int dw);
    int lim;
    int best;
    bit ok;
    lim  = cw + dw - ofs_bits(om);
    best = 0;
    for (int t = 0; t < 48; t++) begin
      if (t <= lim) begin
        ok = 1'b1;
        for (int i = 0; i < 9; i++) begin
          if (!in_range(q_round(longint'(cm[i]), t), cw)) ok = 1'b0;
        end
        if (ok) best = t;
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/csc_in_stage.sv
module csc_in_stage #(
  parameter int DIN_W     = 8,
  parameter int EXT_W     = 9,
  parameter bit SIGNED_IN = 1'b0,
  parameter bit REG_IN    = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    clr,
  input  logic [DIN_W-1:0]        raw [3],
  output logic signed [EXT_W-1:0] ext [3]
);

  logic [DIN_W-1:0] held [3];

  generate
    if (REG_IN) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < 3; k++) held[k] <= '0;
        end else if (clr) begin
          for (int k = 0; k < 3; k++) held[k] <= '0;
        end else if (adv) begin
          for (int k = 0; k < 3; k++) held[k] <= raw[k];
        end
      end
    end else begin : g_pass
      always_comb begin
        for (int k = 0; k < 3; k++) held[k] = raw[k];
      end
    end

    for (genvar k = 0; k < 3; k++) begin : g_ext
      if (SIGNED_IN) begin : g_s
        assign ext[k] = $signed(held[k]);
      end else begin : g_u
        assign ext[k] = $signed({1'b0, held[k]});
      end
    end
  endgenerate

endmodule

// File: rtl/csc_lane.sv
module csc_lane #(
  parameter int     EXT_W  = 9,
  parameter int     COEF_W = 18,
  parameter int     FULL_W = 28,
  parameter longint K0     = 0,
  parameter longint K1     = 0,
  parameter longint K2     = 0,
  parameter longint OFS    = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     clr,
  input  logic signed [EXT_W-1:0]  x0,
  input  logic signed [EXT_W-1:0]  x1,
  input  logic signed [EXT_W-1:0]  x2,
  output logic signed [FULL_W-1:0] y
);

  localparam int PROD_W = EXT_W + COEF_W;
  localparam logic signed [COEF_W-1:0] KC0   = COEF_W'(K0);
  localparam logic signed [COEF_W-1:0] KC1   = COEF_W'(K1);
  localparam logic signed [COEF_W-1:0] KC2   = COEF_W'(K2);
  localparam logic signed [FULL_W-1:0] OFS_V = FULL_W'(OFS);

  logic signed [PROD_W-1:0] m0, m1, m2;
  logic signed [FULL_W-1:0] s01, s2o, tot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0 <= '0; m1 <= '0; m2 <= '0;
      s01 <= '0; s2o <= '0; tot <= '0;
    end else if (clr) begin
      m0 <= '0; m1 <= '0; m2 <= '0;
      s01 <= '0; s2o <= '0; tot <= '0;
    end else if (adv) begin
      m0  <= PROD_W'(x0) * PROD_W'(KC0);
      m1  <= PROD_W'(x1) * PROD_W'(KC1);
      m2  <= PROD_W'(x2) * PROD_W'(KC2);
      s01 <= FULL_W'(m0) + FULL_W'(m1);
      s2o <= FULL_W'(m2) + OFS_V;
      tot <= s01 + s2o;
    end
  end

  assign y = tot;

endmodule

// File: rtl/csc_vld_pipe.sv
module csc_vld_pipe #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  input  logic vin,
  output logic vout
);

  logic [LAT-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (clr)   sh <= '0;
    else if (adv)   sh <= {sh[LAT-2:0], vin};
  end

  assign vout = sh[LAT-1];

endmodule

// File: rtl/csc_matrix3.sv
module csc_matrix3 #(
  parameter int DIN_W          = 8,
  parameter bit SIGNED_IN      = 1'b0,
  parameter int COEF_W         = 18,
  parameter bit REG_IN         = 1'b1,
  parameter int COEF_MILLI [9] = '{257, 504, 98, -148, -291, 439, 439, -368, -71},
  parameter int OFS_MILLI  [3] = '{16000, 128000, 128000},
  localparam int EXT_W  = DIN_W + (SIGNED_IN ? 0 : 1),
  localparam int FULL_W = EXT_W + COEF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sync_clr,
  input  logic              vld_in,
  input  logic [DIN_W-1:0]  src0,
  input  logic [DIN_W-1:0]  src1,
  input  logic [DIN_W-1:0]  src2,
  output logic              vld_out,
  output logic [FULL_W-1:0] res0,
  output logic [FULL_W-1:0] res1,
  output logic [FULL_W-1:0] res2
);

  localparam int SCALE_X = csc_pkg::pick_x(COEF_MILLI, OFS_MILLI, COEF_W, DIN_W);
  localparam int LAT     = 3 + (REG_IN ? 1 : 0);

  // Named pipeline events, also observed by the bound checker.
  logic stage_adv;
  logic stage_clr;
  assign stage_adv = clk_en;
  assign stage_clr = clk_en & sync_clr;

  logic [DIN_W-1:0]         src_a [3];
  logic signed [EXT_W-1:0]  ext_a [3];
  logic signed [FULL_W-1:0] y_a   [3];

  assign src_a[0] = src0;
  assign src_a[1] = src1;
  assign src_a[2] = src2;

  csc_in_stage #(
    .DIN_W(DIN_W), .EXT_W(EXT_W), .SIGNED_IN(SIGNED_IN), .REG_IN(REG_IN)
  ) u_in (
    .clk(clk), .rst_n(rst_n), .adv(stage_adv), .clr(stage_clr),
    .raw(src_a), .ext(ext_a)
  );

  generate
    for (genvar g = 0; g < 3; g++) begin : g_lane
      csc_lane #(
        .EXT_W (EXT_W),
        .COEF_W(COEF_W),
        .FULL_W(FULL_W),
        .K0    (csc_pkg::q_round(longint'(COEF_MILLI[3*g]),   SCALE_X)),
        .K1    (csc_pkg::q_round(longint'(COEF_MILLI[3*g+1]), SCALE_X)),
        .K2    (csc_pkg::q_round(longint'(COEF_MILLI[3*g+2]), SCALE_X)),
        .OFS   (csc_pkg::q_round(longint'(OFS_MILLI[g]),      SCALE_X))
      ) u_lane (
        .clk(clk), .rst_n(rst_n), .adv(stage_adv), .clr(stage_clr),
        .x0(ext_a[0]), .x1(ext_a[1]), .x2(ext_a[2]), .y(y_a[g])
      );
    end
  endgenerate

  csc_vld_pipe #(.LAT(LAT)) u_vld (
    .clk(clk), .rst_n(rst_n), .adv(stage_adv), .clr(stage_clr),
    .vin(vld_in), .vout(vld_out)
  );

  assign res0 = y_a[0];
  assign res1 = y_a[1];
  assign res2 = y_a[2];

endmodule

// File: rtl/csc_matrix3_chk.sv
module csc_matrix3_chk #(
  parameter int LAT    = 4,
  parameter int FULL_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stage_adv,
  input logic              stage_clr,
  input logic              vld_in,
  input logic              vld_out,
  input logic [FULL_W-1:0] res0
);

  // Count of consecutive enabled, uncleared edges, saturating at LAT.
  logic [3:0] streak;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        streak <= '0;
    else if (stage_clr || !stage_adv)  streak <= '0;
    else if (streak < 4'(LAT))         streak <= streak + 4'd1;
  end

  // R5 / R9: valid follows its input after the fixed delay
  p_vld_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (streak >= 4'(LAT)) |-> (vld_out == $past(vld_in, LAT)));

  // R6: a disabled edge changes nothing
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_adv |=> ($stable(vld_out) && $stable(res0)));

  // R7: an enabled clear empties the pipeline
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_clr |=> (!vld_out && (res0 == '0)));

  // R8: leaving reset, outputs are idle and zero
  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!vld_out && (res0 == '0)));

endmodule

bind csc_matrix3 csc_matrix3_chk #(.LAT(LAT), .FULL_W(FULL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stage_adv(stage_adv), .stage_clr(stage_clr),
  .vld_in(vld_in), .vld_out(vld_out), .res0(res0)
);

// File: tb/csc_matrix3_test.sv
`timescale 1ns/1ps
module csc_matrix3_test;

  localparam int FW_U = 28, FW_S = 23, LAT_U = 4, LAT_S = 3;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sr = 1'b0, v = 1'b0;
  logic [7:0] ua = '0, ub = '0, uc = '0;
  logic [9:0] sa = '0, sb = '0, sc = '0;
  logic u_vo, s_vo;
  logic [FW_U-1:0] u_r0, u_r1, u_r2;
  logic [FW_S-1:0] s_r0, s_r1, s_r2;

  int total = 0, bad = 0, cyc = 0;
  bit last_adv = 1'b0, done = 1'b0;
  int xu, xs;

  int CU [9] = '{257, 504, 98, -148, -291, 439, 439, -368, -71};
  int OU [3] = '{16000, 128000, 128000};
  int CS [9] = '{1000, 956, 621, 1000, -272, -647, 1000, -1107, 1704};
  int OS [3] = '{0, 0, 0};

  typedef struct { longint e0; longint e1; longint e2; int cyc; bit lat; } item_t;
  item_t qu[$];
  item_t qs[$];

  always #5 clk = ~clk;

  csc_matrix3 uut (
    .clk(clk), .rst_n(rst_n), .clk_en(ce), .sync_clr(sr), .vld_in(v),
    .src0(ua), .src1(ub), .src2(uc),
    .vld_out(u_vo), .res0(u_r0), .res1(u_r1), .res2(u_r2)
  );

  csc_matrix3 #(
    .DIN_W(10), .SIGNED_IN(1'b1), .COEF_W(12), .REG_IN(1'b0),
    .COEF_MILLI('{1000, 956, 621, 1000, -272, -647, 1000, -1107, 1704}),
    .OFS_MILLI('{0, 0, 0})
  ) uut_s (
    .clk(clk), .rst_n(rst_n), .clk_en(ce), .sync_clr(sr), .vld_in(v),
    .src0(sa), .src1(sb), .src2(sc),
    .vld_out(s_vo), .res0(s_r0), .res1(s_r1), .res2(s_r2)
  );

  // Reference arithmetic, restated from the requirements.
  function automatic longint bq(longint milli, int x);
    longint n, a, r;
    n = milli * (longint'(1) << x);
    a = (n < 0) ? -n : n;
    r = (2 * a + 1000) / 2000;
    return (n < 0) ? -r : r;
  endfunction

  function automatic int bx(int cm [9], int om [3], int cw, int dw);
    int mag, ip, y, lim;
    bit ok;
    longint q, hi;
    mag = 0;
    foreach (om[k]) if ((om[k] < 0 ? -om[k] : om[k]) > mag) mag = (om[k] < 0 ? -om[k] : om[k]);
    ip = (mag + 999) / 1000;
    y = 0;
    while ((1 << y) < ip) y++;
    lim = cw + dw - y;
    hi = (longint'(1) << (cw - 1));
    for (int t = lim; t >= 0; t--) begin
      ok = 1'b1;
      foreach (cm[i]) begin
        q = bq(cm[i], t);
        if (q > hi - 1 || q < -hi) ok = 1'b0;
      end
      if (ok) return t;
    end
    return 0;
  endfunction

  function automatic longint bexp(int cm [9], int om [3], int x, int fw, int k,
                                  longint a, longint b, longint c);
    longint s;
    s = bq(cm[3*k], x) * a + bq(cm[3*k+1], x) * b + bq(cm[3*k+2], x) * c + bq(om[k], x);
    return s & ((longint'(1) << fw) - 1);
  endfunction

  task automatic chk(bit ok, string tag, longint got, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at cycle %0d", tag, got, expv, cyc);
    end
  endtask

  // Driver: one cycle of stimulus; expected items go to the scoreboard queues.
  task automatic step(bit e, bit s, bit vv, logic [7:0] a, logic [7:0] b, logic [7:0] c,
                      logic [9:0] d, logic [9:0] f, logic [9:0] g, bit lat);
    item_t it;
    @(negedge clk); #1;
    ce = e; sr = s; v = vv;
    ua = a; ub = b; uc = c; sa = d; sb = f; sc = g;
    if (e && s) begin
      qu.delete(); qs.delete();
    end else if (e && vv) begin
      it.cyc = cyc; it.lat = lat;
      it.e0 = bexp(CU, OU, xu, FW_U, 0, longint'(a), longint'(b), longint'(c));
      it.e1 = bexp(CU, OU, xu, FW_U, 1, longint'(a), longint'(b), longint'(c));
      it.e2 = bexp(CU, OU, xu, FW_U, 2, longint'(a), longint'(b), longint'(c));
      qu.push_back(it);
      it.e0 = bexp(CS, OS, xs, FW_S, 0, longint'($signed(d)), longint'($signed(f)), longint'($signed(g)));
      it.e1 = bexp(CS, OS, xs, FW_S, 1, longint'($signed(d)), longint'($signed(f)), longint'($signed(g)));
      it.e2 = bexp(CS, OS, xs, FW_S, 2, longint'($signed(d)), longint'($signed(f)), longint'($signed(g)));
      qs.push_back(it);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, ua, ub, uc, sa, sb, sc, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    last_adv <= ce;
  end

  // Monitor: pops one item per enabled edge that shows a valid result.
  always @(negedge clk) begin
    item_t it;
    if (rst_n && last_adv && !done) begin
      if (u_vo) begin
        if (qu.size() == 0) chk(0, "R5 unexpected valid (default)", 1, 0);
        else begin
          it = qu.pop_front();
          chk(longint'(u_r0) == it.e0, "R1 res0", longint'(u_r0), it.e0);
          chk(longint'(u_r1) == it.e1, "R1 res1", longint'(u_r1), it.e1);
          chk(longint'(u_r2) == it.e2, "R1 res2", longint'(u_r2), it.e2);
          if (it.lat) chk(cyc - it.cyc == LAT_U, "R5 latency", cyc - it.cyc, LAT_U);
        end
      end
      if (s_vo) begin
        if (qs.size() == 0) chk(0, "R9 unexpected valid (signed)", 1, 0);
        else begin
          it = qs.pop_front();
          chk(longint'(s_r0) == it.e0, "R4 res0", longint'(s_r0), it.e0);
          chk(longint'(s_r1) == it.e1, "R4 res1", longint'(s_r1), it.e1);
          chk(longint'(s_r2) == it.e2, "R4 res2", longint'(s_r2), it.e2);
          if (it.lat) chk(cyc - it.cyc == LAT_S, "R9 latency", cyc - it.cyc, LAT_S);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW_U-1:0] h0, h1, h2;
    logic [FW_S-1:0] hs0;
    logic hv, hsv;
    xu = bx(CU, OU, 18, 8);
    xs = bx(CS, OS, 12, 10);

    // R8: reset state
    repeat (3) @(negedge clk);
    chk(u_vo == 1'b0 && s_vo == 1'b0, "R8 valid in reset", u_vo, 0);
    chk(u_r0 == '0 && u_r1 == '0 && u_r2 == '0, "R8 default results in reset", u_r0, 0);
    chk(s_r0 == '0 && s_r1 == '0 && s_r2 == '0, "R8 signed results in reset", s_r0, 0);
    @(negedge clk); #1;
    rst_n = 1'b1; ce = 1'b1;

    // R2: zero input yields the scaled offsets alone
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 1);
    idle(LAT_U);
    chk(longint'(u_r0) == 64'd2097152,  "R2 offset out0", longint'(u_r0), 2097152);
    chk(longint'(u_r1) == 64'd16777216, "R2 offset out1", longint'(u_r1), 16777216);
    chk(longint'(u_r2) == 64'd16777216, "R2 offset out2", longint'(u_r2), 16777216);

    // R3 and R4: all-ones unsigned, extreme signed values
    step(1, 0, 1, 8'hFF, 8'hFF, 8'hFF, 10'h200, 10'h1FF, 10'h3FF, 1);
    idle(LAT_U);
    chk(longint'(u_r0) == bexp(CU, OU, xu, FW_U, 0, 255, 255, 255), "R3 zero-extended out0",
        longint'(u_r0), bexp(CU, OU, xu, FW_U, 0, 255, 255, 255));
    chk(longint'(u_r2) == bexp(CU, OU, xu, FW_U, 2, 255, 255, 255), "R3 zero-extended out2",
        longint'(u_r2), bexp(CU, OU, xu, FW_U, 2, 255, 255, 255));
    chk(longint'(s_r2) == bexp(CS, OS, xs, FW_S, 2, -512, 511, -1), "R4 sign-extended out2",
        longint'(s_r2), bexp(CS, OS, xs, FW_S, 2, -512, 511, -1));

    // R5 / R9: back-to-back burst, then sparse valids
    for (int i = 0; i < 40; i++)
      step(1, 0, 1, 8'($urandom), 8'($urandom), 8'($urandom),
           10'($urandom), 10'($urandom), 10'($urandom), 1);
    for (int i = 0; i < 40; i++)
      step(1, 0, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           10'($urandom), 10'($urandom), 10'($urandom), 1);
    idle(6);

    // R6: freeze with clear held high; in-flight items must survive
    for (int i = 0; i < 3; i++)
      step(1, 0, 1, 8'($urandom), 8'($urandom), 8'($urandom),
           10'($urandom), 10'($urandom), 10'($urandom), 0);
    step(0, 1, 1, 8'h11, 8'h22, 8'h33, 10'h111, 10'h222, 10'h333, 0);
    h0 = u_r0; h1 = u_r1; h2 = u_r2; hv = u_vo; hs0 = s_r0; hsv = s_vo;
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           10'($urandom), 10'($urandom), 10'($urandom), 0);
      chk(u_vo == hv && u_r0 == h0 && u_r1 == h1 && u_r2 == h2, "R6 default held",
          longint'(u_r0), longint'(h0));
      chk(s_vo == hsv && s_r0 == hs0, "R6 signed held", longint'(s_r0), longint'(hs0));
    end
    idle(6);

    // R7: enabled clear drops in-flight items and zeroes outputs
    for (int i = 0; i < 3; i++)
      step(1, 0, 1, 8'($urandom), 8'($urandom), 8'($urandom),
           10'($urandom), 10'($urandom), 10'($urandom), 0);
    step(1, 1, 1, 8'h55, 8'h66, 8'h77, 10'h155, 10'h166, 10'h177, 0);
    step(1, 0, 0, 8'h55, 8'h66, 8'h77, 10'h155, 10'h166, 10'h177, 0);
    chk(u_vo == 1'b0 && s_vo == 1'b0, "R7 valid after clear", u_vo, 0);
    chk(u_r0 == '0 && u_r1 == '0 && u_r2 == '0, "R7 default zero after clear", longint'(u_r0), 0);
    chk(s_r0 == '0 && s_r1 == '0 && s_r2 == '0, "R7 signed zero after clear", longint'(s_r0), 0);
    idle(6);

    // R6: random enable gaps; order and values must still hold
    for (int i = 0; i < 60; i++)
      step(1'($urandom), 0, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           10'($urandom), 10'($urandom), 10'($urandom), 0);
    idle(10);
    chk(qu.size() == 0, "R5 default items drained", qu.size(), 0);
    chk(qs.size() == 0, "R9 signed items drained", qs.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule